// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiplier, Degree 163

This block multiplies two elements of the binary field GF(2^163) held in polynomial basis. It forms the product from five bits of the second operand per clock. Each cycle it shifts the running sum up by five places, adds in the first operand times the current five-bit digit, and reduces the result back to 163 bits in the same cycle. A single 163-bit accumulator is therefore the only working storage. The reduction polynomial is f(x) = x^163 + x^7 + x^6 + x^3 + 1.

The second operand is zero-extended at the top to 165 bits, which gives 33 digits. The digits are consumed from the most significant down, so one product takes 33 clocks. A caller pulses `start` with both operands on the buses. The block takes a private copy of the operands, and after that the buses are free to change. When the result is ready the block raises `done` for one clock, and the result stays on `product` until the next accepted start.

Top module: `gf163_digit_mul`

## Requirements
- R1: When `done` is high, `product` equals op_a·op_b mod f(x), where f(x) = x^163 + x^7 + x^6 + x^3 + 1 and bit i of every 163-bit vector is the coefficient of x^i.
- R2: If `start` is sampled high at a rising edge while the block is idle, `done` is high in exactly the cycle that follows the 33rd rising edge after that one.
- R3: `done` is high for one clock per product and is never high in two consecutive cycles.
- R4: While the block is idle and `start` is low, `product` does not change.
- R5: A `start` pulse that arrives while a product is in progress is ignored. The running product is completed with its original operands, and no extra `done` follows.
- R6: The operands are captured at the accepted start. Changes on `op_a` or `op_b` during the computation have no effect on the result.
- R7: Multiplying by the constant 1 returns the other operand unchanged, and multiplying by 0 returns 0, in either operand position.
- R8: After reset, `done` is low, `product` is zero and the block is idle, ready to accept `start`.
- R9: Overflow past degree 162 is folded back through f(x). For example, x^162 · x gives the bits 7, 6, 3 and 0 set, and the all-ones operand squared matches the reduced result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a product; honoured only when idle |
| op_a | input | 163 | Multiplicand, captured at an accepted start |
| op_b | input | 163 | Multiplier, captured at an accepted start and consumed five bits at a time, top digit first |
| product | output | 163 | Reduced product; valid with `done` and held until the next accepted start |
| done | output | 1 | One-cycle pulse when `product` is valid |

## Verification
The hardest case to reach from the ports is a second `start` that lands part-way through a product, together with operand buses that change under a running computation. The bench reaches it by pulsing `start` again, with different operand values, about ten cycles into a run. It also scrambles both buses through the remaining cycles. It then checks that the first result arrives on time and that no second `done` follows. Reduction across the top of the field is driven by directed operands (x^162·x, all ones, the constants 0 and 1) mixed with seeded random pairs. All of these are compared against a schoolbook multiply-then-divide model kept in the bench.

// File: rtl/gf163_mul_pkg.sv
package gf163_mul_pkg;
  localparam int FIELD_M   = 163;
  localparam int DIGIT_W   = 5;
  localparam int NUM_DIG   = (FIELD_M + DIGIT_W - 1) / DIGIT_W;
  localparam int CNT_W     = $clog2(NUM_DIG);
  // low terms of the field polynomial: x^7 + x^6 + x^3 + 1
  localparam logic [FIELD_M-1:0] RED_TAPS =
    (FIELD_M'(1) << 7) | (FIELD_M'(1) << 6) | (FIELD_M'(1) << 3) | FIELD_M'(1);
endpackage

// File: rtl/gf163_digit_pick.sv
module gf163_digit_pick #(
  parameter int M     = 163,
  parameter int W     = 5,
  parameter int NDIG  = (M + W - 1) / W,
  parameter int CW    = $clog2(NDIG)
) (
  input  logic [M-1:0] opb,
  input  logic [CW-1:0] idx,
  output logic [W-1:0] digit
);
  localparam int PADW = NDIG * W;
  localparam int PADZ = PADW - M;

  logic [PADW-1:0] padded;
  logic [CW-1:0]   sel;

  generate
    if (PADZ > 0) begin : g_pad
      assign padded = {{PADZ{1'b0}}, opb};
    end else begin : g_nopad
      assign padded = opb;
    end
  endgenerate

  // index 0 picks the top digit: most significant first
  always_comb begin
    sel   = CW'(NDIG - 1) - idx;
    digit = padded[sel*W +: W];
  end
endmodule

// File: rtl/gf163_step_reduce.sv
module gf163_step_reduce #(
  parameter int M = 163,
  parameter int W = 5,
  parameter logic [M-1:0] TAPS = '0
) (
  input  logic [M-1:0] acc,
  input  logic [M-1:0] opa,
  input  logic [W-1:0] digit,
  output logic [M-1:0] acc_nxt
);
  localparam int EW = M + W;

  logic [EW-1:0] term [W];
  logic [EW-1:0] wide;
  logic [M-1:0]  folded;

  // AND-XOR partial products, one per digit bit
  generate
    for (genvar j = 0; j < W; j++) begin : g_pp
      assign term[j] = digit[j] ? (EW'(opa) << j) : '0;
    end
  endgenerate

  always_comb begin
    wide = {acc, {W{1'b0}}};
    for (int j = 0; j < W; j++) begin
      wide = wide ^ term[j];
    end
  end

  // fold bits M..M+W-1 back using x^M == TAPS
  always_comb begin
    folded = wide[M-1:0];
    for (int i = 0; i < W; i++) begin
      if (wide[M+i]) folded = folded ^ (TAPS << i);
    end
    acc_nxt = folded;
  end
endmodule

// File: rtl/gf163_mul_ctrl.sv
module gf163_mul_ctrl #(
  parameter int NDIG = 33,
  parameter int CW   = $clog2(NDIG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(NDIG - 1);

  logic          busy_n;
  logic [CW-1:0] cnt_n;
  logic          done_n;
  logic          last;

  assign last = (cnt == LAST);
  assign load = start && !busy;

  always_comb begin
    busy_n = busy;
    cnt_n  = cnt;
    done_n = 1'b0;
    if (load) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy) begin
      cnt_n = cnt + 1'b1;
      if (last) begin
        busy_n = 1'b0;
        cnt_n  = '0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      busy <= busy_n;
      cnt  <= cnt_n;
      done <= done_n;
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_late_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/gf163_digit_mul.sv
module gf163_digit_mul
  import gf163_mul_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_M-1:0] op_a,
  input  logic [FIELD_M-1:0] op_b,
  output logic [FIELD_M-1:0] product,
  output logic               done
);
  logic               load;
  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [DIGIT_W-1:0] digit;
  logic [FIELD_M-1:0] a_q, b_q, acc_q;
  logic [FIELD_M-1:0] a_n, b_n, acc_n, acc_step;

  gf163_mul_ctrl #(.NDIG(NUM_DIG), .CW(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .busy(busy), .cnt(cnt), .done(done)
  );

  gf163_digit_pick #(.M(FIELD_M), .W(DIGIT_W), .NDIG(NUM_DIG), .CW(CNT_W)) u_pick (
    .opb(b_q), .idx(cnt), .digit(digit)
  );

  gf163_step_reduce #(.M(FIELD_M), .W(DIGIT_W), .TAPS(RED_TAPS)) u_step (
    .acc(acc_q), .opa(a_q), .digit(digit), .acc_nxt(acc_step)
  );

  always_comb begin
    a_n   = a_q;
    b_n   = b_q;
    acc_n = acc_q;
    if (load) begin
      a_n   = op_a;
      b_n   = op_b;
      acc_n = '0;
    end else if (busy) begin
      acc_n = acc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else begin
      a_q   <= a_n;
      b_q   <= b_n;
      acc_q <= acc_n;
    end
  end

  assign product = acc_q;

  // latency watch: cycles since the accepted start
  logic [CNT_W:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (load)  lat_q <= '0;
    else if (busy)  lat_q <= lat_q + 1'b1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == (CNT_W+1)'(NUM_DIG)));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  assert_operands_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q)));

  assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (product == '0 && busy));
endmodule

// File: tb/gf163_digit_mul_test.sv
module gf163_digit_mul_test;
  localparam int M = 163;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [M-1:0] op_a, op_b;
  logic [M-1:0] product;
  logic         done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gf163_digit_mul uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .product(product), .done(done)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-2:0] full;
    logic [2*M-2:0] fpoly;
    full = '0;
    for (int i = 0; i < M; i++)
      if (b[i]) full = full ^ ((2*M-1)'(a) << i);
    fpoly = ((2*M-1)'(1) << M) | (2*M-1)'(8'hC9);
    for (int k = 2*M-2; k >= M; k--)
      if (full[k]) full = full ^ (fpoly << (k - M));
    return full[M-1:0];
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [191:0] r;
    r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    return r[M-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start at a negedge, then watch 40 cycles; optional late start and bus scrambling
  task automatic run(input logic [M-1:0] a, input logic [M-1:0] b, input string req,
                     input bit disturb);
    logic [M-1:0] exp;
    int done_cnt;
    int done_at;
    exp = ref_mul(a, b);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_cnt = 0; done_at = -1;
    for (int i = 1; i <= 40; i++) begin
      if (disturb) begin
        op_a = rnd(); op_b = rnd();
        start = (i == 10);
      end
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (done_at < 0) begin
          done_at = i;
          check(product == exp, req, product, exp);
        end
      end
    end
    start = 1'b0;
    // R2: done exactly after the 33rd edge; R3 and R5: a single pulse
    check(done_at == 33, "R2", M'(done_at), M'(33));
    check(done_cnt == 1, disturb ? "R5" : "R3", M'(done_cnt), M'(1));
    // R4: still held after idle cycles
    check(product == exp, "R4", product, exp);
  endtask

  initial begin
    logic [M-1:0] ones, x162, x1, r1;
    start = 1'b0; op_a = '0; op_b = '0; rst_n = 1'b0;
    void'($urandom(32'd20240611));
    ones = '1;
    x162 = M'(1) << 162;
    x1   = M'(2);
    repeat (3) @(negedge clk);
    // R8: reset state
    check(done == 1'b0, "R8", M'(done), '0);
    check(product == '0, "R8", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && product == '0, "R8", product, '0);

    r1 = rnd();
    run(r1, M'(1), "R7", 1'b0);
    check(product == r1, "R7", product, r1);
    run(M'(1), r1, "R7", 1'b0);
    check(product == r1, "R7", product, r1);
    run(r1, '0, "R7", 1'b0);
    check(product == '0, "R7", product, '0);
    run('0, r1, "R7", 1'b0);
    run(x162, x1, "R9", 1'b0);
    check(product == M'(8'hC9), "R9", product, M'(8'hC9));
    run(ones, ones, "R9", 1'b0);
    run(ones, rnd(), "R1", 1'b0);
    // R5 and R6: late start plus scrambled buses
    run(rnd(), rnd(), "R6", 1'b1);
    run(ones, ones, "R6", 1'b1);
    for (int t = 0; t < 20; t++) run(rnd(), rnd(), "R1", 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule